// File: doc/BRIEF.md
# Matrix Key Ghost Filter and Change Reporter

This block sits behind a keyboard matrix scanner. Each scan frame carries up to eight entry slots. Each slot has a valid bit and a row and column pair. The block takes one frame at a time and decides whether the set of keys in it could contain phantom presses. Phantom presses appear when keys share both rows and columns. A suspect frame is thrown away as a whole. Any other frame is compared with the last frame that was kept, and the differences go out as a stream of key events.

Every event is a key code and a pressed flag. A sync marker travels on the final event of each frame, so downstream logic can group the events of one scan. For every kept frame the block first sends a release for each previously held key that is now missing. It then sends a press for every key in the new frame.

Both streams use valid/ready handshakes:
- A frame transfers on a cycle where `frm_valid` and `frm_ready` are both high.
- `frm_ready` goes low from that transfer until the last event of the frame has been taken.
- An event transfers on a cycle where `ev_valid` and `ev_ready` are both high.
- While `ev_ready` is low, the event on the output is held unchanged.

Top module: `key_ghost_reporter`

## Requirements
- R1: The ghost test applies only when `filter_en` is high during the frame transfer and the frame has three or more valid slots. A frame with fewer valid slots, or one sent with the filter off, is always kept, even if its keys share rows and columns.
- R2: When the ghost test applies, the frame is dropped if some pair of valid slots shares a row and some pair (possibly a different one) shares a column. A dropped frame emits no events and leaves the stored key set unchanged.
- R3: For a kept frame, each stored key whose code is absent from the frame gives one release event (`ev_pressed`=0), in stored order. All releases of a frame come before any of its presses.
- R4: For a kept frame, each valid slot gives one press event (`ev_pressed`=1). Presses go out in ascending slot order and skip slots whose valid bit is low.
- R5: A kept frame replaces the stored key set with its own valid keys, in slot order, up to eight of them. The releases of the next frame are computed against this set.
- R6: A kept frame with no valid slots releases every stored key and empties the stored set. If the stored set is already empty, such a frame emits nothing.
- R7: The key code is row × 8 + column: `ev_code[6:3]` is the row and `ev_code[2:0]` is the column.
- R8: After reset `frm_ready` is high and `ev_valid` is low. `frm_ready` is low whenever an event is pending, and it returns high in the cycle after the last event of a frame is taken. The first event of a kept frame appears in the cycle after the frame transfer.
- R9: While `ev_valid` is high and `ev_ready` is low, the code, pressed flag and sync marker stay unchanged.
- R10: `ev_last` is high on exactly the final event of each kept frame and low on all its other events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filter_en | input | 1 | Enables the ghost test for the frame being transferred |
| frm_valid | input | 1 | Frame offered |
| frm_ready | output | 1 | Block can take a frame |
| frm_mask | input | 8 | Valid bit per slot |
| frm_row | input | 32 | Row per slot, slot i in bits [4i+3:4i] |
| frm_col | input | 24 | Column per slot, slot i in bits [3i+2:3i] |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Downstream takes the event |
| ev_code | output | 7 | Key code {row, column} |
| ev_pressed | output | 1 | 1 for press, 0 for release |
| ev_last | output | 1 | Final event of the frame |

## Verification
The assertions check the handshake rules on every cycle:
- the input stays blocked while events are pending;
- an event is held during back-pressure;
- no release follows a press within a frame;
- the input reopens right after the sync event.

Some behaviour cannot be seen from one cycle's handshake signals, so only the bench scenarios show it:
- whether a frame is dropped as a ghost;
- which stored keys are released;
- the press order;
- the code arithmetic.

The bench checks these against a reference model that carries the stored key set from frame to frame.

// File: rtl/kgf_pkg.sv
package kgf_pkg;
  localparam int unsigned SLOTS_DEF = 8;
  localparam int unsigned ROW_W_DEF = 4;
  localparam int unsigned COL_W_DEF = 3;
  localparam int unsigned GHOST_MIN_KEYS = 3;
endpackage

// File: rtl/kgf_compact.sv
module kgf_compact #(
  parameter int SLOTS  = 8,
  parameter int CODE_W = 7,
  parameter int CNT_W  = 4
) (
  input  logic [SLOTS-1:0]        mask_i,
  input  logic [SLOTS*CODE_W-1:0] codes_i,
  output logic [SLOTS*CODE_W-1:0] list_o,
  output logic [CNT_W-1:0]        count_o
);
  always_comb begin
    int k;
    k      = 0;
    list_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (mask_i[i]) begin
        list_o[k*CODE_W +: CODE_W] = codes_i[i*CODE_W +: CODE_W];
        k = k + 1;
      end
    end
    count_o = CNT_W'(k);
  end
endmodule

// File: rtl/kgf_ghost_detect.sv
module kgf_ghost_detect #(
  parameter int SLOTS = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  parameter int CNT_W = 4
) (
  input  logic                   enable_i,
  input  logic [SLOTS-1:0]       mask_i,
  input  logic [SLOTS*ROW_W-1:0] rows_i,
  input  logic [SLOTS*COL_W-1:0] cols_i,
  input  logic [CNT_W-1:0]       count_i,
  output logic                   ghost_o
);
  logic row_hit, col_hit;

  always_comb begin
    row_hit = 1'b0;
    col_hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = i + 1; j < SLOTS; j++) begin
        if (mask_i[i] && mask_i[j]) begin
          if (rows_i[i*ROW_W +: ROW_W] == rows_i[j*ROW_W +: ROW_W]) row_hit = 1'b1;
          if (cols_i[i*COL_W +: COL_W] == cols_i[j*COL_W +: COL_W]) col_hit = 1'b1;
        end
      end
    end
  end

  assign ghost_o = enable_i && (count_i >= CNT_W'(kgf_pkg::GHOST_MIN_KEYS)) && row_hit && col_hit;
endmodule

// File: rtl/kgf_pick_first.sv
module kgf_pick_first #(
  parameter int W     = 16,
  parameter int IDX_W = 4
) (
  input  logic [W-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             single_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i] && !found) begin
        idx_o = IDX_W'(i);
        found = 1'b1;
      end
    end
  end

  assign any_o    = |req_i;
  assign single_o = any_o && ((req_i & (req_i - W'(1))) == '0);
endmodule

// File: rtl/key_ghost_reporter.sv
module key_ghost_reporter #(
  parameter int SLOTS = kgf_pkg::SLOTS_DEF,
  parameter int ROW_W = kgf_pkg::ROW_W_DEF,
  parameter int COL_W = kgf_pkg::COL_W_DEF,
  localparam int CODE_W = ROW_W + COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   filter_en,
  input  logic                   frm_valid,
  output logic                   frm_ready,
  input  logic [SLOTS-1:0]       frm_mask,
  input  logic [SLOTS*ROW_W-1:0] frm_row,
  input  logic [SLOTS*COL_W-1:0] frm_col,
  output logic                   ev_valid,
  input  logic                   ev_ready,
  output logic [CODE_W-1:0]      ev_code,
  output logic                   ev_pressed,
  output logic                   ev_last
);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int PEND_W = 2 * SLOTS;
  localparam int PICK_W = $clog2(PEND_W);

  logic [SLOTS*CODE_W-1:0] in_codes, new_list;
  logic [CNT_W-1:0]        new_cnt;
  logic                    ghost;

  // stored set, the set being released, and pending event bits
  // pend[i] (i < SLOTS): release of rel_list slot i
  // pend[SLOTS+i]     : press of cur_list slot i
  logic [SLOTS*CODE_W-1:0] cur_list, rel_list;
  logic [CNT_W-1:0]        cur_cnt;
  logic [PEND_W-1:0]       pend;

  logic [SLOTS-1:0]  rel_mask, prs_mask;
  logic [PICK_W-1:0] pick_idx;
  logic              pick_any, pick_single;
  logic              accept;

  for (genvar g = 0; g < SLOTS; g++) begin : g_code
    assign in_codes[g*CODE_W +: CODE_W] = {frm_row[g*ROW_W +: ROW_W], frm_col[g*COL_W +: COL_W]};
  end

  kgf_compact #(.SLOTS(SLOTS), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_compact (
    .mask_i  (frm_mask),
    .codes_i (in_codes),
    .list_o  (new_list),
    .count_o (new_cnt)
  );

  kgf_ghost_detect #(.SLOTS(SLOTS), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_ghost (
    .enable_i (filter_en),
    .mask_i   (frm_mask),
    .rows_i   (frm_row),
    .cols_i   (frm_col),
    .count_i  (new_cnt),
    .ghost_o  (ghost)
  );

  // set difference: stored keys missing from the incoming frame
  always_comb begin
    for (int p = 0; p < SLOTS; p++) begin
      logic found;
      found = 1'b0;
      for (int n = 0; n < SLOTS; n++) begin
        if ((CNT_W'(n) < new_cnt) &&
            (new_list[n*CODE_W +: CODE_W] == cur_list[p*CODE_W +: CODE_W]))
          found = 1'b1;
      end
      rel_mask[p] = (CNT_W'(p) < cur_cnt) && !found;
      prs_mask[p] = (CNT_W'(p) < new_cnt);
    end
  end

  kgf_pick_first #(.W(PEND_W), .IDX_W(PICK_W)) u_pick (
    .req_i    (pend),
    .idx_o    (pick_idx),
    .any_o    (pick_any),
    .single_o (pick_single)
  );

  assign frm_ready = ~|pend;
  assign accept    = frm_valid && frm_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_list <= '0;
      rel_list <= '0;
      cur_cnt  <= '0;
      pend     <= '0;
    end else if (accept) begin
      if (!ghost) begin
        rel_list <= cur_list;
        cur_list <= new_list;
        cur_cnt  <= new_cnt;
        pend     <= {prs_mask, rel_mask};
      end
    end else if (pick_any && ev_ready) begin
      pend[pick_idx] <= 1'b0;
    end
  end

  assign ev_valid   = pick_any;
  assign ev_last    = pick_single;
  assign ev_pressed = (int'(pick_idx) >= SLOTS);

  always_comb begin
    if (int'(pick_idx) >= SLOTS)
      ev_code = cur_list[(int'(pick_idx) - SLOTS)*CODE_W +: CODE_W];
    else
      ev_code = rel_list[int'(pick_idx)*CODE_W +: CODE_W];
  end
endmodule

// File: rtl/kgf_checker.sv
module kgf_checker #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_ready,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [CODE_W-1:0] ev_code,
  input logic              ev_pressed,
  input logic              ev_last
);
  p_busy_blocks_frames_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !frm_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_code) && $stable(ev_pressed) && $stable(ev_last)));

  // R3: once presses start, no release may follow within the frame
  p_release_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_pressed && !ev_last) |=> (ev_valid && ev_pressed));

  p_sync_ends_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_last) |=> (!ev_valid && frm_ready));

  p_more_after_non_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && !ev_last) |=> ev_valid);
endmodule

bind key_ghost_reporter kgf_checker #(.CODE_W(CODE_W)) u_kgf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_ready  (frm_ready),
  .ev_valid   (ev_valid),
  .ev_ready   (ev_ready),
  .ev_code    (ev_code),
  .ev_pressed (ev_pressed),
  .ev_last    (ev_last)
);

// File: tb/key_ghost_reporter_tb_top.sv
module key_ghost_reporter_tb_top;
  localparam int SLOTS = 8, ROW_W = 4, COL_W = 3, CODE_W = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic filter_en = 1'b0, frm_valid = 1'b0, frm_ready;
  logic [SLOTS-1:0] frm_mask = '0;
  logic [SLOTS*ROW_W-1:0] frm_row = '0;
  logic [SLOTS*COL_W-1:0] frm_col = '0;
  logic ev_valid, ev_ready = 1'b0, ev_pressed, ev_last;
  logic [CODE_W-1:0] ev_code;

  always #10 clk = ~clk;

  key_ghost_reporter dut_i (
    .clk(clk), .rst_n(rst_n), .filter_en(filter_en),
    .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_mask(frm_mask), .frm_row(frm_row), .frm_col(frm_col),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code),
    .ev_pressed(ev_pressed), .ev_last(ev_last)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  int mdl_keys[SLOTS];
  int mdl_cnt = 0;
  int exp_code[2*SLOTS];
  bit exp_prs[2*SLOTS];
  int exp_n;

  logic [SLOTS-1:0] d_mask;
  logic [SLOTS*ROW_W-1:0] d_row;
  logic [SLOTS*COL_W-1:0] d_col;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic clear_keys();
    d_mask = '0; d_row = '0; d_col = '0;
  endtask

  task automatic set_key(input int slot, input int row, input int col);
    d_mask[slot] = 1'b1;
    d_row[slot*ROW_W +: ROW_W] = ROW_W'(row);
    d_col[slot*COL_W +: COL_W] = COL_W'(col);
  endtask

  // reference model: ghost decision, release/press list, stored set update
  task automatic build_expect(input bit flt, input logic [SLOTS-1:0] m,
                              input logic [SLOTS*ROW_W-1:0] r, input logic [SLOTS*COL_W-1:0] c);
    int cur[SLOTS];
    int cr[SLOTS];
    int cc[SLOTS];
    int n;
    bit rh, ch, ghost;
    n = 0; rh = 0; ch = 0;
    for (int i = 0; i < SLOTS; i++)
      if (m[i]) begin
        cr[n] = int'(r[i*ROW_W +: ROW_W]);
        cc[n] = int'(c[i*COL_W +: COL_W]);
        cur[n] = cr[n] * 8 + cc[n];
        n++;
      end
    for (int i = 0; i < n; i++)
      for (int j = i + 1; j < n; j++) begin
        if (cr[i] == cr[j]) rh = 1;
        if (cc[i] == cc[j]) ch = 1;
      end
    ghost = flt && (n >= 3) && rh && ch;
    exp_n = 0;
    if (!ghost) begin
      for (int p = 0; p < mdl_cnt; p++) begin
        bit f;
        f = 0;
        for (int q = 0; q < n; q++) if (cur[q] == mdl_keys[p]) f = 1;
        if (!f) begin exp_code[exp_n] = mdl_keys[p]; exp_prs[exp_n] = 0; exp_n++; end
      end
      for (int q = 0; q < n; q++) begin
        exp_code[exp_n] = cur[q]; exp_prs[exp_n] = 1; exp_n++;
      end
      for (int q = 0; q < n; q++) mdl_keys[q] = cur[q];
      mdl_cnt = n;
    end
  endtask

  task automatic run_frame(input string tag, input bit flt, input logic [SLOTS-1:0] m,
                           input logic [SLOTS*ROW_W-1:0] r, input logic [SLOTS*COL_W-1:0] c,
                           input int rdy_pct);
    int k, cyc;
    bit stalled;
    logic [CODE_W-1:0] held;
    build_expect(flt, m, r, c);
    @(negedge clk);
    chk(frm_ready === 1'b1, {tag, " R8 ready when idle"}, int'(frm_ready), 1);
    filter_en = flt; frm_mask = m; frm_row = r; frm_col = c; frm_valid = 1'b1;
    @(negedge clk);
    frm_valid = 1'b0;
    k = 0; cyc = 0; stalled = 0; held = '0;
    while (k < exp_n && cyc < 400) begin
      bit rdy;
      if (stalled && ev_valid)
        chk(ev_code == held, {tag, " R9 code held under stall"}, int'(ev_code), int'(held));
      if (ev_valid) chk(frm_ready == 1'b0, {tag, " R8 ready low while busy"}, int'(frm_ready), 0);
      rdy = (int'($urandom % 100) < rdy_pct);
      ev_ready = rdy;
      stalled = ev_valid && !rdy;
      held = ev_code;
      if (ev_valid && rdy) begin
        if (exp_prs[k])
          chk(ev_code == CODE_W'(exp_code[k]) && ev_pressed, {tag, " R4 press code/order"},
              int'(ev_code), exp_code[k]);
        else
          chk(ev_code == CODE_W'(exp_code[k]) && !ev_pressed, {tag, " R3 release code/order"},
              int'(ev_code), exp_code[k]);
        chk(ev_last == (k == exp_n - 1), {tag, " R10 sync marker"}, int'(ev_last), int'(k == exp_n - 1));
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    ev_ready = 1'b0;
    if (k < exp_n) chk(0, {tag, " R8 events missing"}, k, exp_n);
    chk(!ev_valid && frm_ready, {tag, " R8 idle after frame (R2 no extra events)"},
        int'(ev_valid), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frm_ready === 1'b1 && ev_valid === 1'b0, "R8 reset state", int'(ev_valid), 0);

    // R7: single key at highest row and column gives code 127
    clear_keys(); set_key(3, 15, 7);
    run_frame("R7", 1, d_mask, d_row, d_col, 100);
    // R4 + R3: skipped slots, release of the old key, entry order
    clear_keys(); set_key(0, 2, 1); set_key(2, 5, 4); set_key(6, 9, 0);
    run_frame("R4", 1, d_mask, d_row, d_col, 100);
    // R2: shared row (0,1) and shared column (0,2) with filter on -> dropped
    clear_keys(); set_key(0, 1, 1); set_key(1, 1, 2); set_key(2, 3, 1);
    run_frame("R2", 1, d_mask, d_row, d_col, 100);
    // R5: stored set still the R4 frame, this frame releases part of it
    clear_keys(); set_key(1, 5, 4); set_key(4, 12, 6);
    run_frame("R5", 1, d_mask, d_row, d_col, 100);
    // R1: same ghost pattern with the filter off is kept
    clear_keys(); set_key(0, 1, 1); set_key(1, 1, 2); set_key(2, 3, 1);
    run_frame("R1", 0, d_mask, d_row, d_col, 100);
    // R1: two identical keys share row and column but are under three
    clear_keys(); set_key(0, 6, 6); set_key(5, 6, 6);
    run_frame("R1", 1, d_mask, d_row, d_col, 100);
    // R1: three keys sharing only a row pass the filter
    clear_keys(); set_key(0, 4, 0); set_key(1, 4, 3); set_key(2, 4, 5);
    run_frame("R1", 1, d_mask, d_row, d_col, 100);
    // R9: full eight-key frame, distinct diagonal, with heavy back-pressure
    clear_keys();
    for (int i = 0; i < SLOTS; i++) set_key(i, i + 8, i);
    run_frame("R9", 1, d_mask, d_row, d_col, 25);
    // R6: empty frame releases all eight, then empty again emits nothing
    clear_keys();
    run_frame("R6", 1, d_mask, d_row, d_col, 60);
    run_frame("R6", 1, d_mask, d_row, d_col, 100);

    // random frames with narrow row/column ranges to provoke overlap
    for (int t = 0; t < 400; t++) begin
      clear_keys();
      if ($urandom % 8 != 0)
        for (int i = 0; i < SLOTS; i++)
          if ($urandom % 3 == 0) set_key(i, int'($urandom % 4), int'($urandom % 4));
      run_frame("R2", 1'($urandom % 2), d_mask, d_row, d_col, 40 + int'($urandom % 61));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule